// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block decides which interrupt the CPU takes next. It merges two kinds of request into one arbiter. The first is a 4-bit encoded external level whose code is also its priority. The second is a set of twelve request lines from six on-chip peripheral groups: divider, DMA controller, serial interface, bus controller, watchdog and free-running timer. Software gives each peripheral priority field a level from 0 to 15 through a small register write/read port. The watchdog and the bus controller share one field.

Each cycle the block finds the pending source with the highest level. Equal levels resolve by a fixed order. If the winner's level is strictly above the CPU's current mask level, the block registers an accept. It then holds the winning level and a vector number that is unique to that source until the CPU acknowledges. The CPU copies the presented level into its mask bits. Vector table fetch and context stacking belong to the CPU.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every priority field reads 0, both registers read 0x0000 and `irq_valid` is low.
- R2: Priority register 0 (`reg_sel`=0) holds the divider level in bits 15:12, the DMA level in bits 11:8 and the watchdog/bus-controller level in bits 7:4. Priority register 1 (`reg_sel`=1) holds the serial level in bits 15:12 and the timer level in bits 11:8. All other bits ignore writes and read as 0.
- R3: A nonzero external code n requests at level n with vector 64+n. Code 0 is no request.
- R4: An external code counts only when it was sampled equal on two consecutive clocks, so a code present for a single clock is never accepted. A stable code is accepted on the third rising edge after it is applied.
- R5: Peripheral source i (0..11) requests at its group's field level with vector 80+i. The sources are: 0 divider; 1 and 2 DMA channels; 3 watchdog; 4 bus controller; 5 to 8 serial (error, receive, transmit, transmit end); 9 to 11 timer (capture, compare, overflow). A peripheral request is accepted on the first rising edge after it is raised.
- R6: A request is accepted only if its level is strictly greater than `mask_lvl`. A source at level 0 is never accepted.
- R7: Among pending sources, the one with the highest level wins.
- R8: At equal levels the external request wins over all peripheral sources. Among peripheral sources the lower index wins, and this also fixes the order of sources that share one field.
- R9: While `irq_valid` is high, `irq_level` and `irq_vector` do not change until `irq_ack` is sampled high. On the edge that samples `irq_ack`, `irq_valid` falls.
- R10: `irq_level` equals the level of the accepted source, ready to be loaded into the CPU mask bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_code | input | 4 | Encoded external request level |
| per_req | input | 12 | Peripheral source request lines |
| mask_lvl | input | 4 | Current CPU mask level |
| reg_sel | input | 1 | Priority register select |
| reg_we | input | 1 | Priority register write enable |
| reg_wdata | input | 16 | Priority register write data |
| reg_rdata | output | 16 | Priority register read data (combinational) |
| irq_ack | input | 1 | CPU acknowledge of the presented interrupt |
| irq_valid | output | 1 | Interrupt accepted and pending acknowledge |
| irq_level | output | 4 | Level of the accepted interrupt |
| irq_vector | output | 8 | Vector number of the accepted interrupt |

## Verification
Every cycle, assertions check four things: the held level and vector stay put until acknowledge, `irq_valid` falls after acknowledge, a new accept always lies above the mask sampled on that edge, and the glitch filter never passes a code that was not seen on two consecutive clocks. Only the bench scenarios can show which source wins. That covers the level comparison, the tie order between external and peripheral sources and within a shared field, the exact vector numbers, the register layout with its zero-reading reserved bits, and the rejection of a one-clock external code.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W   = 4;
  localparam int NSRC    = 12;
  localparam int NFLD    = 5;
  localparam int FLD_W   = $clog2(NFLD);
  localparam int REG_W   = 16;

  typedef enum logic [FLD_W-1:0] {
    F_DIV = 3'd0,
    F_DMA = 3'd1,
    F_WDT = 3'd2,
    F_SCI = 3'd3,
    F_FRT = 3'd4
  } fld_e;

  typedef logic [NFLD-1:0][LVL_W-1:0] prio_vec_t;

  // Source index -> priority field; index order is also the tie order.
  function automatic fld_e src_field(input int idx);
    fld_e f;
    if (idx == 0)      f = F_DIV;
    else if (idx <= 2) f = F_DMA;
    else if (idx <= 4) f = F_WDT;
    else if (idx <= 8) f = F_SCI;
    else               f = F_FRT;
    return f;
  endfunction
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output prio_vec_t        prio_o
);
  prio_vec_t prio_q;
  prio_vec_t prio_d;
  logic      wr_a;
  logic      wr_b;

  assign wr_a = reg_we && !reg_sel;
  assign wr_b = reg_we &&  reg_sel;

  always_comb begin
    prio_d = prio_q;
    if (wr_a) begin
      prio_d[F_DIV] = reg_wdata[15:12];
      prio_d[F_DMA] = reg_wdata[11:8];
      prio_d[F_WDT] = reg_wdata[7:4];
    end
    if (wr_b) begin
      prio_d[F_SCI] = reg_wdata[15:12];
      prio_d[F_FRT] = reg_wdata[11:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prio_q <= '0;
    else if (reg_we)
      prio_q <= prio_d;
  end

  always_comb begin
    if (reg_sel)
      reg_rdata = {prio_q[F_SCI], prio_q[F_FRT], 8'h00};
    else
      reg_rdata = {prio_q[F_DIV], prio_q[F_DMA], prio_q[F_WDT], 4'h0};
  end

  assign prio_o = prio_q;
endmodule

// File: rtl/irq_ext_filter.sv
module irq_ext_filter
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] ext_code,
  output logic [LVL_W-1:0] ext_lvl
);
  logic [LVL_W-1:0] samp1_q;
  logic [LVL_W-1:0] samp2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp1_q <= '0;
      samp2_q <= '0;
    end else begin
      samp1_q <= ext_code;
      samp2_q <= samp1_q;
    end
  end

  assign ext_lvl = (samp1_q == samp2_q) ? samp1_q : '0;

  // R4: a code is passed only if the input held it on the two prior edges
  a_r4_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_lvl != '0) |-> ($past(ext_code, 1) == ext_lvl && $past(ext_code, 2) == ext_lvl));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int VEC_W        = 8,
  parameter int EXT_VEC_BASE = 64,
  parameter int PER_VEC_BASE = 80
) (
  input  logic [LVL_W-1:0] ext_lvl,
  input  logic [NSRC-1:0]  per_req,
  input  prio_vec_t        prio,
  input  logic [LVL_W-1:0] mask_lvl,
  output logic             win_valid,
  output logic [LVL_W-1:0] win_level,
  output logic [VEC_W-1:0] win_vector
);
  logic [NSRC-1:0][LVL_W-1:0] src_lvl;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      localparam fld_e FLD = src_field(g);
      assign src_lvl[g] = per_req[g] ? prio[FLD] : '0;
    end
  endgenerate

  // External first, then ascending index; strict compare keeps the earlier on ties.
  always_comb begin
    win_level  = ext_lvl;
    win_vector = VEC_W'(EXT_VEC_BASE) + VEC_W'(ext_lvl);
    for (int i = 0; i < NSRC; i++) begin
      if (src_lvl[i] > win_level) begin
        win_level  = src_lvl[i];
        win_vector = VEC_W'(PER_VEC_BASE + i);
      end
    end
    win_valid = (win_level > mask_lvl);
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int VEC_W        = 8,
  parameter int EXT_VEC_BASE = 64,
  parameter int PER_VEC_BASE = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ext_code,
  input  logic [11:0]      per_req,
  input  logic [3:0]       mask_lvl,
  input  logic             reg_sel,
  input  logic             reg_we,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic             irq_ack,
  output logic             irq_valid,
  output logic [3:0]       irq_level,
  output logic [VEC_W-1:0] irq_vector
);
  logic             rs1_q;
  logic             rs2_q;
  logic             irst_n;
  prio_vec_t        prio;
  logic [LVL_W-1:0] ext_lvl;
  logic             win_valid;
  logic [LVL_W-1:0] win_level;
  logic [VEC_W-1:0] win_vector;

  logic             valid_q, valid_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic [VEC_W-1:0] vec_q,   vec_d;
  logic             load;
  logic             clear;
  logic             acc_en;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign irst_n = rs2_q;

  irq_prio_regs u_regs (
    .clk       (clk),
    .rst_n     (irst_n),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .prio_o    (prio)
  );

  irq_ext_filter u_filt (
    .clk      (clk),
    .rst_n    (irst_n),
    .ext_code (ext_code),
    .ext_lvl  (ext_lvl)
  );

  irq_arbiter #(
    .VEC_W        (VEC_W),
    .EXT_VEC_BASE (EXT_VEC_BASE),
    .PER_VEC_BASE (PER_VEC_BASE)
  ) u_arb (
    .ext_lvl    (ext_lvl),
    .per_req    (per_req),
    .prio       (prio),
    .mask_lvl   (mask_lvl),
    .win_valid  (win_valid),
    .win_level  (win_level),
    .win_vector (win_vector)
  );

  // Accept register: load when idle, clear on acknowledge
  assign load   = !valid_q && win_valid;
  assign clear  =  valid_q && irq_ack;
  assign acc_en = load || clear;

  always_comb begin
    valid_d = valid_q;
    level_d = level_q;
    vec_d   = vec_q;
    if (load) begin
      valid_d = 1'b1;
      level_d = win_level;
      vec_d   = win_vector;
    end else if (clear) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      valid_q <= 1'b0;
      level_q <= '0;
      vec_q   <= '0;
    end else if (acc_en) begin
      valid_q <= valid_d;
      level_q <= level_d;
      vec_q   <= vec_d;
    end
  end

  assign irq_valid  = valid_q;
  assign irq_level  = level_q;
  assign irq_vector = vec_q;

  // R9: presented interrupt is frozen until acknowledged
  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!irst_n)
    (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_level) && $stable(irq_vector)));

  // R9: acknowledge drops the valid flag
  a_r9_clear_on_ack: assert property (@(posedge clk) disable iff (!irst_n)
    (irq_valid && irq_ack) |=> !irq_valid);

  // R6: a fresh accept lies strictly above the mask seen on that edge
  a_r6_above_mask: assert property (@(posedge clk) disable iff (!irst_n)
    $rose(irq_valid) |-> (irq_level > $past(mask_lvl)));

  // R10: an accepted level is never zero
  a_r10_nonzero_level: assert property (@(posedge clk) disable iff (!irst_n)
    irq_valid |-> (irq_level != '0));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  ext_code;
  logic [11:0] per_req;
  logic [3:0]  mask_lvl;
  logic        reg_sel;
  logic        reg_we;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq_ack;
  logic        irq_valid;
  logic [3:0]  irq_level;
  logic [7:0]  irq_vector;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_code(ext_code), .per_req(per_req),
    .mask_lvl(mask_lvl), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
    .irq_valid(irq_valid), .irq_level(irq_level), .irq_vector(irq_vector)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
    edges(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output int v);
    reg_sel = sel;
    #1 v = int'(reg_rdata);
  endtask

  task automatic ack_all();
    ext_code = 4'd0; per_req = '0; irq_ack = 1'b1;
    edges(1);
    irq_ack = 1'b0;
    chk("R9 valid cleared after ack", int'(irq_valid), 0);
    edges(2);
  endtask

  task automatic expect_irq(input string tag, input int lvl, input int vec);
    chk({tag, " valid"}, int'(irq_valid), 1);
    chk({tag, " level"}, int'(irq_level), lvl);
    chk({tag, " vector"}, int'(irq_vector), vec);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 valid low after reset", int'(irq_valid), 0);
    rd(1'b0, v); chk("R1 reg0 reset", v, 0);
    rd(1'b1, v); chk("R1 reg1 reset", v, 0);
  endtask

  task automatic t_regs();
    int v;
    wr(1'b0, 16'hFFFF); rd(1'b0, v); chk("R2 reg0 reserved zero", v, 16'hFFF0);
    wr(1'b1, 16'hFFFF); rd(1'b1, v); chk("R2 reg1 reserved zero", v, 16'hFF00);
    wr(1'b0, 16'h123F); rd(1'b0, v); chk("R2 reg0 fields", v, 16'h1230);
    wr(1'b1, 16'h56AB); rd(1'b1, v); chk("R2 reg1 fields", v, 16'h5600);
  endtask

  task automatic t_ext();
    mask_lvl = 4'd0; ext_code = 4'd9;
    edges(2);
    chk("R4 not yet accepted after two edges", int'(irq_valid), 0);
    edges(1);
    expect_irq("R3 ext code 9", 9, 73);
    ack_all();
  endtask

  task automatic t_glitch();
    ext_code = 4'd7;
    edges(1);
    ext_code = 4'd0;
    for (int k = 0; k < 5; k++) begin
      edges(1);
      chk("R4 one-clock glitch rejected", int'(irq_valid), 0);
    end
  endtask

  task automatic t_per();
    // fields: div1 dma2 wdt3 sci5 frt6
    per_req = 12'h800;
    edges(1);
    expect_irq("R5 timer overflow", 6, 91);
    ack_all();
    per_req = 12'h002;
    edges(1);
    expect_irq("R5 dma ch0", 2, 81);
    ack_all();
  endtask

  task automatic t_mask();
    mask_lvl = 4'd6; per_req = 12'h400;
    edges(2);
    chk("R6 equal to mask blocked", int'(irq_valid), 0);
    mask_lvl = 4'd5;
    edges(1);
    expect_irq("R6 above mask accepted", 6, 90);
    ack_all();
    wr(1'b0, 16'h0230);
    mask_lvl = 4'd0; per_req = 12'h001;
    edges(3);
    chk("R6 level zero never accepted", int'(irq_valid), 0);
    per_req = '0;
    edges(1);
  endtask

  task automatic t_highest();
    wr(1'b0, 16'h3450); wr(1'b1, 16'h2100);
    mask_lvl = 4'd0; per_req = 12'hFFF;
    edges(1);
    expect_irq("R7 highest wins, R8 watchdog before bus", 5, 83);
    ack_all();
    per_req = 12'h1F0;
    edges(1);
    expect_irq("R8 bus controller shares field", 5, 84);
    ack_all();
  endtask

  task automatic t_tie();
    wr(1'b0, 16'h5550); wr(1'b1, 16'h5500);
    mask_lvl = 4'd15; ext_code = 4'd5; per_req = 12'hFFF;
    edges(3);
    chk("R6 blocked by mask 15", int'(irq_valid), 0);
    mask_lvl = 4'd4;
    edges(1);
    expect_irq("R8 external wins tie", 5, 69);
    ack_all();
    mask_lvl = 4'd15; per_req = 12'h284;
    edges(1);
    mask_lvl = 4'd4;
    edges(1);
    expect_irq("R8 lower index wins tie", 5, 82);
    ack_all();
    per_req = 12'h120;
    edges(1);
    expect_irq("R8 serial error before transmit end", 5, 85);
    ack_all();
  endtask

  task automatic t_hold();
    mask_lvl = 4'd0; per_req = 12'h200;
    edges(1);
    expect_irq("R10 timer capture level", 5, 89);
    ext_code = 4'd12; mask_lvl = 4'd14; per_req = 12'h001;
    for (int k = 0; k < 4; k++) begin
      edges(1);
      chk("R9 valid held", int'(irq_valid), 1);
      chk("R9 level held", int'(irq_level), 5);
      chk("R9 vector held", int'(irq_vector), 89);
    end
    ack_all();
  endtask

  initial begin
    fork
      begin
        rst_n = 1'b0; ext_code = '0; per_req = '0; mask_lvl = '0;
        reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = '0; irq_ack = 1'b0;
        edges(3);
        rst_n = 1'b1;
        edges(4);
        t_reset();
        t_regs();
        t_ext();
        t_glitch();
        t_per();
        t_mask();
        t_highest();
        t_tie();
        t_hold();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule